// File: doc/BRIEF.md
# Frame Base Address Double Buffer with Frame Interrupt

This block keeps the start address of the frame buffer that a raster display controller scans out. Software may write a new address through a small register port at any moment. The block keeps that value as a pending address. On each frame boundary, which the timing generator marks with a one-cycle `frame_start` pulse, the block copies the pending address into the active address. The memory fetch logic reads the active address, so an address never changes part way through a frame.

Each copy also sets a status bit that reports the new address as taken. Software uses this bit as its vertical blank event. The port gives software an enable mask, a raw status view, a masked status view and a write-one-to-clear register. The interrupt line is a registered OR of the masked status bits.

Register map (word offsets on `reg_addr`):

| Offset | Name | Access |
|---|---|---|
| 0 | pending base | read/write |
| 1 | active base | read-only |
| 2 | enable mask | read/write |
| 3 | raw status | read-only |
| 4 | masked status | read-only |
| 5 | clear | write-only |

Offsets 6 and 7 read as zero. Writes to read-only or unmapped offsets are ignored.

Top module: `fbase_update_unit`

## Requirements
- R1: After reset, the pending base, the active base, the enable mask, the raw status, `reg_rdata` for every offset, `active_base` and `irq` are all zero.
- R2: `active_base` changes only on the cycle after a `frame_start` pulse. A write to the pending base (offset 0) leaves `active_base` unchanged until the next pulse.
- R3: The two lowest bits of a written base address are discarded. They read as zero at offset 0 and at offset 1, and they are zero on `active_base`.
- R4: A pending-base write in the same cycle as `frame_start` does not reach the active base for that frame. The previous pending value is transferred, and the new value waits for the following pulse.
- R5: On the cycle after a `frame_start` pulse, status bit 0 reads as 1 at offset 3. Without a pulse or a clear, the status keeps its value.
- R6: Offset 4 returns the raw status ANDed with the enable mask. With the mask at zero it reads 0, while offset 3 still reports the raw status.
- R7: Writing to offset 5 clears each status bit that has a 1 in the written data. Zero bits leave status unchanged, and writing back the value read from offset 4 clears the pending event. Offset 5 reads as 0.
- R8: When a clear of bit 0 and a `frame_start` pulse fall in the same cycle, status bit 0 is 1 afterwards.
- R9: `irq` equals the OR of the masked status bits as they were one cycle earlier.
- R10: The enable mask is bit 0 of offset 2. The upper bits of a write are dropped and read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word offset for the write and the read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| active_base | output | DATA_W | Base address in use for the current frame |
| irq | output | 1 | Registered interrupt line |

## Verification
Two pairs of operations can fall in the same cycle. In the first pair, a pending-base write meets a frame boundary. In the second, a clear write meets the status set that a frame boundary causes. The bench provokes both pairs with directed cycles that put `reg_wr_en` and `frame_start` on the same clock. It then also provokes them at random over a long run. A behavioural reference model, updated on every edge, gives the expected active address, read data and interrupt. These expectations follow the rule that the old pending value moves to the active address and that the status set wins over the clear.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

   // Register word offsets; software depends on these values.
   typedef enum logic [2:0] {
      FBU_PEND = 3'd0,
      FBU_ACT  = 3'd1,
      FBU_IEN  = 3'd2,
      FBU_RAW  = 3'd3,
      FBU_MSK  = 3'd4,
      FBU_CLR  = 3'd5
   } fbu_reg_e;

   localparam int unsigned FBU_MAP_BITS = 3;

endpackage

// File: rtl/fbu_base_buffer.sv
module fbu_base_buffer #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] pend_q,
   output logic [DATA_W-1:0] act_q
);

   logic [DATA_W-1:0] wr_aligned;

   generate
      if (ALIGN_BITS == 0) begin : g_no_align
         assign wr_aligned = wr_data;
      end else begin : g_align
         assign wr_aligned = {wr_data[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
   endgenerate

   // Shadow register: software side.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
      end else if (wr_en) begin
         pend_q <= wr_aligned;
      end
   end

   // Active register: loaded only at the frame boundary, from the old shadow.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= '0;
      end else if (frame_start) begin
         act_q <= pend_q;
      end
   end

   assert_hold_mid_frame_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_q));

   assert_old_shadow_taken_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (act_q == $past(pend_q)));

endmodule

// File: rtl/fbu_irq_ctrl.sv
module fbu_irq_ctrl #(
   parameter int unsigned SRC_W   = 1,
   parameter bit          IRQ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] set_evt,
   input  logic             en_wr,
   input  logic [SRC_W-1:0] en_data,
   input  logic             clr_wr,
   input  logic [SRC_W-1:0] clr_data,
   output logic [SRC_W-1:0] en_q,
   output logic [SRC_W-1:0] raw_q,
   output logic [SRC_W-1:0] msk,
   output logic             irq
);

   logic [SRC_W-1:0] clr_mask;

   assign clr_mask = clr_wr ? clr_data : '0;
   assign msk      = raw_q & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (en_wr) begin
         en_q <= en_data;
      end
   end

   // A new event overrides a clear in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw_q <= '0;
      end else begin
         raw_q <= (raw_q & ~clr_mask) | set_evt;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_flop
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q <= 1'b0;
            end else begin
               irq_q <= |msk;
            end
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = |msk;
      end
   endgenerate

   assert_event_sets_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (|set_evt) |=> ((raw_q & $past(set_evt)) == $past(set_evt)));

   assert_status_holds_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_wr && !(|set_evt)) |=> $stable(raw_q));

   assert_clear_works_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && !(|set_evt)) |=> ((raw_q & $past(clr_data)) == '0));

   assert_set_beats_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr && (|(clr_data & set_evt))) |=> ((raw_q & $past(clr_data & set_evt)) != '0));

endmodule

// File: rtl/fbase_update_unit.sv
module fbase_update_unit #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned ALIGN_BITS = 2,
   parameter bit          IRQ_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              reg_wr_en,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] active_base,
   output logic              irq
);

   import fbu_pkg::*;

   localparam int unsigned SRC_W = 1;
   localparam int unsigned PAD_W = DATA_W - SRC_W;

   generate
      if (ADDR_W < FBU_MAP_BITS) begin : g_bad_addr
         $error("ADDR_W too small for the register map");
      end
      if (ALIGN_BITS >= DATA_W) begin : g_bad_align
         $error("ALIGN_BITS must be below DATA_W");
      end
      if (DATA_W <= SRC_W) begin : g_bad_data
         $error("DATA_W too small");
      end
   endgenerate

   logic              sel_pend, sel_ien, sel_clr;
   logic [DATA_W-1:0] pend_q, act_q;
   logic [SRC_W-1:0]  en_q, raw_q, msk;

   assign sel_pend = reg_wr_en && (reg_addr == ADDR_W'(FBU_PEND));
   assign sel_ien  = reg_wr_en && (reg_addr == ADDR_W'(FBU_IEN));
   assign sel_clr  = reg_wr_en && (reg_addr == ADDR_W'(FBU_CLR));

   fbu_base_buffer #(
      .DATA_W     (DATA_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) i_base (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .wr_en       (sel_pend),
      .wr_data     (reg_wdata),
      .pend_q      (pend_q),
      .act_q       (act_q)
   );

   fbu_irq_ctrl #(
      .SRC_W   (SRC_W),
      .IRQ_REG (IRQ_REG)
   ) i_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_evt  (frame_start),
      .en_wr    (sel_ien),
      .en_data  (reg_wdata[SRC_W-1:0]),
      .clr_wr   (sel_clr),
      .clr_data (reg_wdata[SRC_W-1:0]),
      .en_q     (en_q),
      .raw_q    (raw_q),
      .msk      (msk),
      .irq      (irq)
   );

   assign active_base = act_q;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(FBU_PEND)) begin
         reg_rdata = pend_q;
      end else if (reg_addr == ADDR_W'(FBU_ACT)) begin
         reg_rdata = act_q;
      end else if (reg_addr == ADDR_W'(FBU_IEN)) begin
         reg_rdata = {{PAD_W{1'b0}}, en_q};
      end else if (reg_addr == ADDR_W'(FBU_RAW)) begin
         reg_rdata = {{PAD_W{1'b0}}, raw_q};
      end else if (reg_addr == ADDR_W'(FBU_MSK)) begin
         reg_rdata = {{PAD_W{1'b0}}, msk};
      end
   end

endmodule

// File: tb/test_fbase_update_unit.sv
module test_fbase_update_unit;

   localparam int  CLK_PERIOD = 10;
   localparam int  DW         = 32;
   localparam int  AW         = 3;
   localparam int  MAX_CYC    = 20000;
   localparam logic [DW-1:0] ALIGN_MASK = 32'hFFFF_FFFC;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_start = 1'b0;
   logic          reg_wr_en = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [DW-1:0] active_base;
   logic          irq;

   int vectors = 0;
   int fails   = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   // Reference model state
   logic [DW-1:0] m_pend = '0;
   logic [DW-1:0] m_act  = '0;
   logic          m_en   = 1'b0;
   logic          m_stat = 1'b0;
   logic          m_irq  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fbase_update_unit i_fbase_update_unit (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .reg_wr_en   (reg_wr_en),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .active_base (active_base),
      .irq         (irq)
   );

   // Behavioural model, updated from the inputs driven at the previous negedge.
   always @(posedge clk) begin
      logic [DW-1:0] n_pend, n_act;
      logic          n_en, n_stat, n_irq;
      if (!rst_n) begin
         m_pend = '0; m_act = '0; m_en = 1'b0; m_stat = 1'b0; m_irq = 1'b0;
      end else begin
         n_irq  = m_stat && m_en;                       // R9
         n_act  = frame_start ? m_pend : m_act;        // R2, R4
         n_pend = m_pend;
         n_en   = m_en;
         n_stat = m_stat;
         if (reg_wr_en && reg_addr == 3'd0) n_pend = reg_wdata & ALIGN_MASK; // R3
         if (reg_wr_en && reg_addr == 3'd2) n_en = reg_wdata[0];             // R10
         if (reg_wr_en && reg_addr == 3'd5 && reg_wdata[0]) n_stat = 1'b0;   // R7
         if (frame_start) n_stat = 1'b1;                                     // R5, R8
         m_pend = n_pend; m_act = n_act; m_en = n_en; m_stat = n_stat; m_irq = n_irq;
      end
   end

   function automatic logic [DW-1:0] model_read(input logic [AW-1:0] a);
      case (a)
         3'd0:    return m_pend;
         3'd1:    return m_act;
         3'd2:    return {31'd0, m_en};
         3'd3:    return {31'd0, m_stat};
         3'd4:    return {31'd0, m_stat && m_en};   // R6
         default: return '0;
      endcase
   endfunction

   function automatic string addr_tag(input logic [AW-1:0] a);
      case (a)
         3'd0, 3'd1: return "R3";
         3'd2:       return "R10";
         3'd3:       return "R5";
         3'd4:       return "R6";
         3'd5:       return "R7";
         default:    return "R1";
      endcase
   endfunction

   task automatic compare(input string ctx);
      logic [DW-1:0] exp_rd;
      exp_rd = model_read(reg_addr);
      vectors++;
      if (active_base !== m_act) begin
         fails++;
         $display("FAIL R2/R4 %s active_base=%h expected=%h", ctx, active_base, m_act);
      end
      vectors++;
      if (irq !== m_irq) begin
         fails++;
         $display("FAIL R9 %s irq=%b expected=%b", ctx, irq, m_irq);
      end
      vectors++;
      if (reg_rdata !== exp_rd) begin
         fails++;
         $display("FAIL %s %s addr=%0d rdata=%h expected=%h",
                  addr_tag(reg_addr), ctx, reg_addr, reg_rdata, exp_rd);
      end
   endtask

   // One cycle: check the settled state, then drive the next inputs.
   task automatic step(input string ctx, input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic fs);
      @(negedge clk);
      compare(ctx);
      reg_wr_en = we; reg_addr = a; reg_wdata = d; frame_start = fs;
   endtask

   task automatic peek(input string ctx, input logic [AW-1:0] a);
      step(ctx, 1'b0, a, '0, 1'b0);
   endtask

   initial begin
      // R1: reset state observed at every offset
      repeat (3) @(negedge clk);
      for (int a = 0; a < 8; a++) begin
         reg_addr = AW'(a);
         #1;
         vectors++;
         if (reg_rdata !== '0 || active_base !== '0 || irq !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset addr=%0d rdata=%h active=%h irq=%b expected=0",
                     a, reg_rdata, active_base, irq);
         end
      end
      reg_addr = '0;
      rst_n = 1'b1;

      // R3, R2: write pending, active unchanged until a boundary
      step("R3 write", 1'b1, 3'd0, 32'h1234_5677, 1'b0);
      peek("R3 readback", 3'd0);
      peek("R2 no boundary", 3'd1);
      peek("R2 still", 3'd1);
      step("R5 boundary", 1'b0, 3'd1, '0, 1'b1);
      peek("R2 after", 3'd1);
      peek("R5 raw", 3'd3);
      // R6: masked while enable is zero
      peek("R6 masked", 3'd4);
      // R10: enable with upper bits set
      step("R10 enable", 1'b1, 3'd2, 32'hFFFF_FFFF, 1'b0);
      peek("R10 readback", 3'd2);
      peek("R6 unmasked", 3'd4);
      peek("R9 irq", 3'd4);
      // R7: zero write leaves status, one clears, offset 5 reads zero
      step("R7 clear zero", 1'b1, 3'd5, 32'h0, 1'b0);
      peek("R7 after zero", 3'd3);
      step("R7 write back", 1'b1, 3'd5, 32'h1, 1'b0);
      peek("R7 cleared", 3'd3);
      peek("R7 read clr", 3'd5);
      peek("R9 irq drop", 3'd4);
      // R4: pending write coincident with boundary
      step("R4 pre", 1'b1, 3'd0, 32'hAAAA_0000, 1'b0);
      step("R4 coincide", 1'b1, 3'd0, 32'h5555_1111, 1'b1);
      peek("R4 act old", 3'd1);
      peek("R4 pend new", 3'd0);
      step("R4 next frame", 1'b0, 3'd1, '0, 1'b1);
      peek("R4 act new", 3'd1);
      // R8: clear coincident with boundary
      step("R8 coincide", 1'b1, 3'd5, 32'h1, 1'b1);
      peek("R8 status", 3'd3);
      peek("R8 masked", 3'd4);
      // mask off again: raw still updates (R6)
      step("R6 mask off", 1'b1, 3'd2, 32'h0, 1'b0);
      step("R6 clr", 1'b1, 3'd5, 32'h1, 1'b0);
      step("R6 boundary", 1'b0, 3'd3, '0, 1'b1);
      peek("R6 raw", 3'd3);
      peek("R6 msk", 3'd4);

      // Random traffic, including collisions of writes and boundaries
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] a;
         a = AW'($urandom_range(0, 7));
         step("random", ($urandom_range(0, 2) == 0), a, $urandom(),
              ($urandom_range(0, 9) == 0));
      end
      step("tail", 1'b0, 3'd0, '0, 1'b0);
      peek("tail", 3'd4);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   // Watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > MAX_CYC && !done) begin
         fails++;
         $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule